// File: doc/BRIEF.md
# Level-Match GPIO Interrupt Controller

A 32-pin general-purpose I/O block with a small register bus. Each pin can be a plain GPIO or be handed to an alternate peripheral function. A per-pin select bit picks the owner of the pad's output value and output enable. In GPIO mode a direction bit decides whether the pin drives the pad. A data register supplies the value the pin drives. Pad inputs pass through a two-flop synchronizer before software reads them or the interrupt logic uses them. Pins 0 to 3 are meant for a UART's transmit, receive, RTS and CTS signals. Pin 1 also serves as a push-button input.

Every pin also has an interrupt detector. Software programs a level bit for the pin. Whenever the synchronized pin value equals that level, the pin's status bit is latched and stays set until software clears it. A per-pin routing bit sends a pending status bit either to the non-maskable output or to the ordinary interrupt output. Clearing a bit while its pin still sits at the programmed level only clears it for one cycle.

Top module: `gpio_lvl_ctrl`

## Requirements
- R1: When a pin's function-select bit is 1, pad_out and pad_oe for that pin follow alt_out and alt_oe.
- R2: When a pin's function-select bit is 0, pad_oe equals its direction bit (1 = output) and pad_out equals its data-register bit.
- R3: A change on pad_in appears on alt_in and in data-register reads exactly two clock edges later. One edge later the old value is still seen.
- R4: On each clock edge that is not a status write, a status bit is set if the synchronized pin value equals its level bit. The bit becomes visible after that edge. Pins whose value differs from their level bit do not set.
- R5: A set status bit stays set until a status write carries 0 in its position. Writing 1 to a status bit never sets it.
- R6: A status write with a 0 bit clears that bit on the write edge. If the pin still matches its level, the bit is set again one edge later.
- R7: nmi is the OR of the status bits whose NMI-routing bit is 1. irq is the OR of the status bits whose routing bit is 0.
- R8: Word addresses are 0 function select, 1 direction, 2 data, 3 interrupt level, 4 interrupt status, 5 NMI routing. Reads are combinational from bus_addr. A read of address 2 returns the synchronized pad value, not the written data.
- R9: Addresses 6 and 7 read as zero, and writes to them change no register or output.
- R10: While rst_n is low, every register is zero, pad_oe is zero, and irq and nmi are low. After reset the pins are GPIO inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register word address |
| bus_we | input | 1 | Write strobe, taken on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pad_in | input | 32 | Raw pad input levels |
| pad_out | output | 32 | Value driven toward each pad |
| pad_oe | output | 32 | Pad output enable, 1 = drive |
| alt_out | input | 32 | Alternate-function output values |
| alt_oe | input | 32 | Alternate-function output enables |
| alt_in | output | 32 | Synchronized pad values for the alternate functions |
| irq | output | 1 | Maskable interrupt request |
| nmi | output | 1 | Non-maskable interrupt request |

## Verification
The hardest case to reach is a status clear that lands while the pin still matches its level. The bit must read zero for exactly one cycle and then come back. The stimulus holds a pad at the programmed level and routes that pin to nmi. It then clears the bit and samples the status register and nmi on the two cycles that follow the write. A one-cycle pad pulse shows stickiness after the match is gone, and the bench also opens the window between a pad edge and its synchronized effect. A long random phase then mixes bus writes with pad toggles. A behavioural model checks every cycle.

// File: rtl/gpio_lvl_pkg.sv
package gpio_lvl_pkg;
   localparam int unsigned SEL_W     = 3;
   localparam int unsigned REG_COUNT = 6;

   typedef enum logic [SEL_W-1:0] {
      REG_FSEL  = 3'd0,
      REG_DIR   = 3'd1,
      REG_DATA  = 3'd2,
      REG_LVL   = 3'd3,
      REG_STAT  = 3'd4,
      REG_NMIEN = 3'd5
   } reg_sel_e;
endpackage

// File: rtl/gpio_lvl_sync.sv
module gpio_lvl_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_lvl_regs.sv
module gpio_lvl_regs
   import gpio_lvl_pkg::*;
#(
   parameter int unsigned NPINS  = 32,
   parameter int unsigned BUS_W  = 32,
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BUS_W-1:0]  wdata,
   input  logic [NPINS-1:0]  pin_s,
   input  logic [NPINS-1:0]  sts,
   output logic [NPINS-1:0]  fsel,
   output logic [NPINS-1:0]  dir,
   output logic [NPINS-1:0]  dout,
   output logic [NPINS-1:0]  lvl,
   output logic [NPINS-1:0]  nmien,
   output logic              sts_clr,
   output logic [NPINS-1:0]  sts_keep,
   output logic [BUS_W-1:0]  rdata
);
   localparam logic [SEL_W-1:0] LAST_IDX = SEL_W'(REG_COUNT - 1);

   logic [SEL_W-1:0]                 lo;
   logic                             in_map;
   logic [REG_COUNT-1:0]             wsel;
   logic [REG_COUNT-1:0][NPINS-1:0]  bank;

   assign lo = addr[SEL_W-1:0];

   generate
      if (ADDR_W > SEL_W) begin : g_wide_addr
         assign in_map = (addr[ADDR_W-1:SEL_W] == '0) && (lo <= LAST_IDX);
      end else begin : g_exact_addr
         assign in_map = (lo <= LAST_IDX);
      end

      for (genvar k = 0; k < REG_COUNT; k++) begin : g_reg
         assign wsel[k] = we && in_map && (lo == SEL_W'(k));
         if (k == int'(REG_STAT)) begin : g_stat_view
            assign bank[k] = sts;
         end else begin : g_flop
            logic [NPINS-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)       q <= '0;
               else if (wsel[k]) q <= wdata[NPINS-1:0];
            end
            assign bank[k] = q;
         end
      end
   endgenerate

   assign fsel     = bank[REG_FSEL];
   assign dir      = bank[REG_DIR];
   assign dout     = bank[REG_DATA];
   assign lvl      = bank[REG_LVL];
   assign nmien    = bank[REG_NMIEN];
   assign sts_clr  = wsel[REG_STAT];
   assign sts_keep = wdata[NPINS-1:0];

   always_comb begin
      rdata = '0;
      if (in_map) begin
         if (lo == REG_DATA) rdata[NPINS-1:0] = pin_s;
         else                rdata[NPINS-1:0] = bank[lo];
      end
   end
endmodule

// File: rtl/gpio_lvl_irq.sv
module gpio_lvl_irq #(
   parameter int unsigned NPINS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pin_s,
   input  logic [NPINS-1:0] lvl,
   input  logic [NPINS-1:0] nmien,
   input  logic             clr,
   input  logic [NPINS-1:0] keep,
   output logic [NPINS-1:0] sts,
   output logic             irq,
   output logic             nmi
);
   logic [NPINS-1:0] hit;

   assign hit = ~(pin_s ^ lvl);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sts <= '0;
      else if (clr) sts <= sts & keep;
      else          sts <= sts | hit;
   end

   assign nmi = |(sts & nmien);
   assign irq = |(sts & ~nmien);

   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (($past(sts) & ~sts) == '0)); // R5
   AST_SET_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((sts & ~$past(sts) & ~$past(hit)) == '0)); // R4
   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> ((sts & ~$past(keep)) == '0)); // R6
   AST_LINES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (sts == '0) |-> (!irq && !nmi)); // R7
   AST_PENDING_SIGNALLED: assert property (@(posedge clk) disable iff (!rst_n)
      (sts != '0) |-> (irq || nmi)); // R7
endmodule

// File: rtl/gpio_lvl_padmux.sv
module gpio_lvl_padmux #(
   parameter int unsigned NPINS = 32
) (
   input  logic [NPINS-1:0] fsel,
   input  logic [NPINS-1:0] dir,
   input  logic [NPINS-1:0] dout,
   input  logic [NPINS-1:0] alt_out,
   input  logic [NPINS-1:0] alt_oe,
   output logic [NPINS-1:0] pad_out,
   output logic [NPINS-1:0] pad_oe
);
   generate
      for (genvar i = 0; i < NPINS; i++) begin : g_pin
         assign pad_out[i] = fsel[i] ? alt_out[i] : dout[i];
         assign pad_oe[i]  = fsel[i] ? alt_oe[i]  : dir[i];
      end
   endgenerate
endmodule

// File: rtl/gpio_lvl_ctrl.sv
module gpio_lvl_ctrl #(
   parameter int unsigned NPINS       = 32,
   parameter int unsigned BUS_W       = 32,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [NPINS-1:0]  pad_in,
   output logic [NPINS-1:0]  pad_out,
   output logic [NPINS-1:0]  pad_oe,
   input  logic [NPINS-1:0]  alt_out,
   input  logic [NPINS-1:0]  alt_oe,
   output logic [NPINS-1:0]  alt_in,
   output logic              irq,
   output logic              nmi
);
   generate
      if (NPINS < 1 || NPINS > BUS_W) begin : g_bad_pins
         $error("NPINS must lie between 1 and BUS_W");
      end
      if (ADDR_W < gpio_lvl_pkg::SEL_W) begin : g_bad_addr
         $error("ADDR_W too narrow for the register map");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [NPINS-1:0] pin_s, fsel, dir, dout, lvl, nmien, sts, sts_keep;
   logic             sts_clr;

   gpio_lvl_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_s)
   );

   gpio_lvl_regs #(.NPINS(NPINS), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
      .pin_s(pin_s), .sts(sts), .fsel(fsel), .dir(dir), .dout(dout), .lvl(lvl),
      .nmien(nmien), .sts_clr(sts_clr), .sts_keep(sts_keep), .rdata(bus_rdata)
   );

   gpio_lvl_irq #(.NPINS(NPINS)) u_irq (
      .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .lvl(lvl), .nmien(nmien),
      .clr(sts_clr), .keep(sts_keep), .sts(sts), .irq(irq), .nmi(nmi)
   );

   gpio_lvl_padmux #(.NPINS(NPINS)) u_mux (
      .fsel(fsel), .dir(dir), .dout(dout), .alt_out(alt_out), .alt_oe(alt_oe),
      .pad_out(pad_out), .pad_oe(pad_oe)
   );

   assign alt_in = pin_s;

   logic [1:0] fill;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             fill <= '0;
      else if (fill != 2'd3)  fill <= fill + 2'd1;
   end

   generate
      if (SYNC_STAGES == 2) begin : g_sync_chk
         AST_SYNC_TWO: assert property (@(posedge clk) disable iff (!rst_n)
            (fill == 2'd3) |-> (alt_in == $past(pad_in, 2))); // R3
      end
   endgenerate

   AST_ALT_OWNS_PAD: assert property (@(posedge clk) disable iff (!rst_n)
      (((pad_oe ^ alt_oe) | (pad_out ^ alt_out)) & fsel) == '0); // R1
endmodule

// File: tb/gpio_lvl_ctrl_test.sv
module gpio_lvl_ctrl_test;
   localparam int N  = 32;
   localparam int BW = 32;
   localparam int AW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          we = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [BW-1:0] wdata = '0;
   logic [N-1:0]  pad_in = '0, alt_out = '0, alt_oe = '0;
   logic [BW-1:0] rd_data;
   logic [N-1:0]  pad_out, pad_oe, alt_in;
   logic          irq, nmi;

   gpio_lvl_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
      .bus_rdata(rd_data), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
      .alt_out(alt_out), .alt_oe(alt_oe), .alt_in(alt_in), .irq(irq), .nmi(nmi)
   );

   always #5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // behavioural reference state
   logic [31:0] m_fsel, m_dir, m_dout, m_lvl, m_nmien, m_sts, m_s1, m_s2;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_fsel <= 0; m_dir <= 0; m_dout <= 0; m_lvl <= 0;
         m_nmien <= 0; m_sts <= 0; m_s1 <= 0; m_s2 <= 0;
      end else begin
         m_s1 <= pad_in;
         m_s2 <= m_s1;
         if (we) begin
            case (addr)
               3'd0: m_fsel  <= wdata;
               3'd1: m_dir   <= wdata;
               3'd2: m_dout  <= wdata;
               3'd3: m_lvl   <= wdata;
               3'd5: m_nmien <= wdata;
               default: ;
            endcase
         end
         if (we && addr == 3'd4) m_sts <= m_sts & wdata;
         else                    m_sts <= m_sts | ~(m_s2 ^ m_lvl);
      end
   end

   function automatic logic [31:0] exp_rd(input logic [2:0] a);
      case (a)
         3'd0: return m_fsel;
         3'd1: return m_dir;
         3'd2: return m_s2;
         3'd3: return m_lvl;
         3'd4: return m_sts;
         3'd5: return m_nmien;
         default: return 32'h0;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic finish_run;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // per-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n && !done) begin
         #2;
         chk("R1 R2 pad_out", pad_out, (m_fsel & alt_out) | (~m_fsel & m_dout));
         chk("R1 R2 pad_oe",  pad_oe,  (m_fsel & alt_oe)  | (~m_fsel & m_dir));
         chk("R3 alt_in",     alt_in,  m_s2);
         chk("R7 irq", {31'b0, irq}, {31'b0, |(m_sts & ~m_nmien)});
         chk("R7 nmi", {31'b0, nmi}, {31'b0, |(m_sts & m_nmien)});
         chk("R8 R9 rd_data", rd_data, exp_rd(addr));
      end
   end

   initial begin
      #(150000 * 10);
      if (!done) begin
         errors++;
         $display("FAIL R10 watchdog actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      // R10: reset state
      repeat (3) @(negedge clk);
      #2;
      chk("R10 pad_oe", pad_oe, 32'h0);
      chk("R10 irq", {31'b0, irq}, 32'h0);
      chk("R10 nmi", {31'b0, nmi}, 32'h0);
      for (int a = 0; a < 8; a++) begin
         addr = 3'(a);
         #1 chk("R10 register read", rd_data, 32'h0);
      end

      // R4: idle-low pads match the zero level right after reset
      @(negedge clk); rst_n = 1'b1; addr = 3'd4;
      @(negedge clk); #2;
      chk("R4 match after reset", rd_data, 32'hFFFF_FFFF);
      chk("R4 irq after reset", {31'b0, irq}, 32'h1);

      wr(3'd3, 32'hFFFF_FFFF);
      wr(3'd4, 32'h0);
      addr = 3'd4; #2;
      chk("R5 status cleared", rd_data, 32'h0);
      @(negedge clk); #2;
      chk("R4 mismatch stays clear", rd_data, 32'h0);
      chk("R4 irq low", {31'b0, irq}, 32'h0);

      // R2: GPIO direction and data
      wr(3'd1, 32'h0000_FFFF);
      wr(3'd2, 32'hA5A5_1234);
      #2;
      chk("R2 pad_oe", pad_oe, 32'h0000_FFFF);
      chk("R2 pad_out", pad_out, 32'hA5A5_1234);
      addr = 3'd2; #1;
      chk("R8 data read is pad state", rd_data, 32'h0);

      // R1: alternate function on pins 0..3
      alt_out = 32'h5; alt_oe = 32'h9;
      wr(3'd0, 32'hF);
      #2;
      chk("R1 pad_out", pad_out, 32'hA5A5_1235);
      chk("R1 pad_oe", pad_oe, 32'h0000_FFF9);

      // R3/R4: synchronizer latency and level match on pin 5
      @(negedge clk); pad_in = 32'h20; addr = 3'd2;
      @(negedge clk); #2;
      chk("R3 one edge later", rd_data, 32'h0);
      chk("R3 alt_in one edge", alt_in, 32'h0);
      @(negedge clk); #2;
      chk("R3 two edges later", rd_data, 32'h20);
      chk("R3 alt_in two edges", alt_in, 32'h20);
      chk("R4 not yet latched", {31'b0, irq}, 32'h0);
      @(negedge clk); addr = 3'd4; #2;
      chk("R4 status latched", rd_data, 32'h20);
      chk("R4 irq raised", {31'b0, irq}, 32'h1);

      // R7: route pin 5 to nmi
      wr(3'd5, 32'h20);
      #2;
      chk("R7 nmi routed", {31'b0, nmi}, 32'h1);
      chk("R7 irq masked", {31'b0, irq}, 32'h0);

      // R6: clear while the match persists
      wr(3'd4, 32'h0);
      addr = 3'd4; #2;
      chk("R6 cleared one cycle", rd_data, 32'h0);
      chk("R6 nmi drops", {31'b0, nmi}, 32'h0);
      @(negedge clk); #2;
      chk("R6 set again", rd_data, 32'h20);
      chk("R6 nmi returns", {31'b0, nmi}, 32'h1);

      // R5: writing ones does not set, pulse is held
      @(negedge clk); pad_in = 32'h0;
      repeat (4) @(negedge clk);
      wr(3'd4, 32'h0);
      addr = 3'd4; #2;
      chk("R5 clear with no match", rd_data, 32'h0);
      wr(3'd4, 32'hFFFF_FFFF);
      addr = 3'd4; #2;
      chk("R5 write one ignored", rd_data, 32'h0);
      chk("R5 lines idle", {30'b0, irq, nmi}, 32'h0);
      @(negedge clk); pad_in = 32'h20;
      @(negedge clk); pad_in = 32'h0;
      repeat (5) @(negedge clk);
      addr = 3'd4; #2;
      chk("R5 pulse held", rd_data, 32'h20);
      chk("R5 nmi held", {31'b0, nmi}, 32'h1);

      // R9: unmapped addresses
      wr(3'd6, 32'hFFFF_FFFF);
      wr(3'd7, 32'hFFFF_FFFF);
      addr = 3'd6; #1 chk("R9 read 6", rd_data, 32'h0);
      addr = 3'd7; #1 chk("R9 read 7", rd_data, 32'h0);
      addr = 3'd0; #1 chk("R9 fsel kept", rd_data, 32'hF);
      addr = 3'd1; #1 chk("R9 dir kept", rd_data, 32'h0000_FFFF);
      addr = 3'd3; #1 chk("R9 level kept", rd_data, 32'hFFFF_FFFF);
      addr = 3'd5; #1 chk("R9 routing kept", rd_data, 32'h20);
      chk("R9 pad_out kept", pad_out, 32'hA5A5_1235);

      // random phase, compared every cycle
      for (int n = 0; n < 3000; n++) begin
         @(negedge clk);
         we      = ($urandom % 4) == 0;
         addr    = 3'($urandom);
         wdata   = $urandom;
         pad_in  = pad_in ^ ($urandom & $urandom & $urandom);
         alt_out = $urandom;
         alt_oe  = $urandom;
      end
      @(negedge clk); we = 1'b0;
      @(negedge clk); #3;
      done = 1;
      finish_run();
   end
endmodule